// File: doc/BRIEF.md
# Chopped-Channel Offset Estimator and Demodulator

This block sits behind one sub-converter of a time-interleaved ADC whose analog input was multiplied by an alternating +1/-1 square code before conversion. Each accepted sample is multiplied by the same code again, which restores the signal. Because the code has zero mean over a frame, the channel's static offset is cancelled without any subtraction. The demodulated stream goes downstream one cycle after each sample.

In parallel, the raw samples of a frame of L samples are summed. The all-ones summing code and the alternating code are orthogonal, so the frame sum divided by L is the channel's offset estimate. L is a power of two, so the division is an arithmetic shift with round-half-up. The estimate is emitted with a one-cycle valid pulse. L (32, 64 or 128) and the output fixed-point format (8.6, 8.7 or 8.8) are chosen per frame. A synchronous restart realigns the frame with the analog chopping phase.

Top module: `chop_offset_est`

## Requirements
- R1: After reset, `dm_valid` and `off_valid` are low, and the first accepted sample is multiplied by +1.
- R2: One cycle after a cycle with `in_valid` high, `dm_valid` is high and `dm_data` = floor((c*x + h)/2^d). Here x is the signed 8.8 input, h = 2^(d-1) (0 when d=0), and c is +1 for even and -1 for odd sample indices within the frame.
- R3: `restart` high sets the frame index to 0 and discards the partial sum, and no `off_valid` is issued for the abandoned frame. A sample accepted in the same cycle as `restart` is index 0 of the new frame.
- R4: One cycle after the L-th sample of a frame, `off_valid` is high for exactly one cycle. `off_data` = floor((S + 2^(s-1)) / 2^s), where S is the sum of the frame's raw samples and s = log2(L) + d.
- R5: `len_sel` encoding: 0 gives L=32, 1 gives L=64, 2 or 3 gives L=128.
- R6: `fmt_sel` encoding: 0 gives 8.6 (d=2), 1 gives 8.7 (d=1), 2 or 3 gives 8.8 (d=0). The format applies to both `dm_data` and `off_data`.
- R7: `len_sel` and `fmt_sel` are captured with the first sample of a frame. Changing them later in the frame has no effect on that frame's outputs.
- R8: Cycles with `in_valid` low do not advance the frame index or the code, and are followed by `dm_valid` low.
- R9: No overflow occurs. A full L=128 frame of -32768 gives `off_data` -32768, a frame of +32767 gives +32767, and -32768 multiplied by -1 gives `dm_data` +32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Synchronous frame restart |
| len_sel | input | 2 | Frame length select |
| fmt_sel | input | 2 | Output format select |
| in_valid | input | 1 | Sample strobe |
| in_data | input | IN_W | Signed 8.8 raw sample |
| dm_valid | output | 1 | Demodulated sample valid |
| dm_data | output | IN_W+1 | Signed demodulated sample in selected format |
| off_valid | output | 1 | Offset estimate valid, one cycle |
| off_data | output | IN_W | Signed offset estimate in selected format |

## Verification
A code flip-flop that drifts out of phase shows up on the very next demodulated sample as a sign-inverted value. A wrong frame counter moves the `off_valid` pulse away from the L-th sample, so it is caught at the first frame end. A stale partial sum or a mis-latched configuration corrupts the next offset estimate one cycle after its frame closes. Half-way sums check the rounding direction, and full-scale frames check the guard bits.

// File: rtl/chop_offset_est.sv
module chop_offset_est #(
  parameter int IN_W          = 16,
  parameter int FRAME_MIN_LOG = 5,
  parameter int LEN_STEPS     = 3,
  parameter int DROP_MAX      = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   restart,
  input  logic [1:0]             len_sel,
  input  logic [1:0]             fmt_sel,
  input  logic                   in_valid,
  input  logic signed [IN_W-1:0] in_data,
  output logic                   dm_valid,
  output logic signed [IN_W:0]   dm_data,
  output logic                   off_valid,
  output logic signed [IN_W-1:0] off_data
);
  localparam int MAX_LOG = FRAME_MIN_LOG + LEN_STEPS - 1;
  localparam int CNT_W   = MAX_LOG;
  localparam int ACC_W   = IN_W + MAX_LOG;

  logic [CNT_W-1:0]        cnt;
  logic                    neg;
  logic signed [ACC_W-1:0] acc;
  logic [1:0]              lat_len, lat_fmt;

  logic                    first;
  logic [1:0]              len_e, fmt_e, len_c, fmt_c;
  logic [3:0]              len_log, drop, off_sh;
  logic [CNT_W-1:0]        cnt_e, frame_top;
  logic                    last, code_neg;
  logic signed [ACC_W-1:0] sum;
  logic signed [IN_W:0]    prod;
  logic signed [IN_W+1:0]  dm_x;
  logic signed [ACC_W:0]   off_x;

  assign first    = restart | (cnt == '0);
  assign len_e    = first ? len_sel : lat_len;
  assign fmt_e    = first ? fmt_sel : lat_fmt;
  assign len_c    = (len_e > 2'(LEN_STEPS - 1)) ? 2'(LEN_STEPS - 1) : len_e;
  assign fmt_c    = (fmt_e > 2'(DROP_MAX)) ? 2'(DROP_MAX) : fmt_e;
  assign len_log  = 4'(FRAME_MIN_LOG) + {2'b00, len_c};
  assign drop     = 4'(DROP_MAX) - {2'b00, fmt_c};
  assign off_sh   = len_log + drop;

  assign cnt_e     = restart ? '0 : cnt;
  assign frame_top = ~({CNT_W{1'b1}} << len_log);
  assign last      = (cnt_e == frame_top);
  assign code_neg  = restart ? 1'b0 : neg;

  assign sum  = (first ? '0 : acc) + ACC_W'(in_data);
  assign prod = code_neg ? -(IN_W+1)'(in_data) : (IN_W+1)'(in_data);
  assign dm_x = (IN_W+2)'(prod) + (IN_W+2)'(((IN_W+2)'(1) << drop) >> 1);
  assign off_x = (ACC_W+1)'(sum) + (ACC_W+1)'(((ACC_W+1)'(1) << off_sh) >> 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      neg       <= 1'b0;
      acc       <= '0;
      lat_len   <= '0;
      lat_fmt   <= '0;
      dm_valid  <= 1'b0;
      dm_data   <= '0;
      off_valid <= 1'b0;
      off_data  <= '0;
    end else begin
      dm_valid  <= in_valid;
      off_valid <= in_valid & last;
      if (in_valid) begin
        acc     <= sum;
        cnt     <= last ? '0 : cnt_e + 1'b1;
        neg     <= last ? 1'b0 : ~code_neg;
        lat_len <= len_e;
        lat_fmt <= fmt_e;
        dm_data <= (IN_W+1)'(dm_x >>> drop);
        if (last) off_data <= IN_W'(off_x >>> off_sh);
      end else if (restart) begin
        cnt <= '0;
        neg <= 1'b0;
      end
    end
  end
endmodule

module chop_offset_est_chk #(
  parameter int IN_W = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   restart,
  input logic                   in_valid,
  input logic                   dm_valid,
  input logic signed [IN_W:0]   dm_data,
  input logic                   off_valid
);
  localparam logic signed [IN_W:0] LIM = (IN_W+1)'(1) <<< (IN_W - 1);

  a_r4_off_single: assert property (@(posedge clk) disable iff (!rst_n)
    off_valid |=> !off_valid);
  a_r4_off_with_dm: assert property (@(posedge clk) disable iff (!rst_n)
    off_valid |-> dm_valid);
  a_r2_dm_follow: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> dm_valid);
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !dm_valid);
  a_r3_restart_no_end: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !off_valid);
  a_r9_dm_range: assert property (@(posedge clk) disable iff (!rst_n)
    dm_valid |-> (dm_data <= LIM) && (dm_data >= -LIM));
endmodule

bind chop_offset_est chop_offset_est_chk #(.IN_W(IN_W)) u_chk (.*);

// File: tb/tb_chop_offset_est.sv
module tb_chop_offset_est;
  localparam int IN_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic restart = 1'b0;
  logic [1:0] len_sel = 2'd0;
  logic [1:0] fmt_sel = 2'd2;
  logic in_valid = 1'b0;
  logic signed [IN_W-1:0] in_data = '0;
  logic dm_valid, off_valid;
  logic signed [IN_W:0] dm_data;
  logic signed [IN_W-1:0] off_data;

  always #2 clk = ~clk;

  chop_offset_est dut (
    .clk(clk), .rst_n(rst_n), .restart(restart), .len_sel(len_sel),
    .fmt_sel(fmt_sel), .in_valid(in_valid), .in_data(in_data),
    .dm_valid(dm_valid), .dm_data(dm_data),
    .off_valid(off_valid), .off_data(off_data));

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  longint exp_dm[$];  string tag_dm[$];
  longint exp_off[$]; string tag_off[$];

  int m_cnt = 0, m_log = 5, m_drop = 0;
  longint m_acc = 0;

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(input longint x, input bit rs, input string tdm, input string toff);
    longint p; int s;
    restart = rs; in_valid = 1'b1; in_data = IN_W'(x);
    if (rs) m_cnt = 0;
    if (m_cnt == 0) begin
      m_log  = 5 + ((len_sel > 2) ? 2 : int'(len_sel));
      m_drop = 2 - ((fmt_sel > 2) ? 2 : int'(fmt_sel));
      m_acc  = 0;
    end
    p = (m_cnt % 2 == 1) ? -x : x;
    exp_dm.push_back((p + ((longint'(1) << m_drop) >> 1)) >>> m_drop);
    tag_dm.push_back(tdm);
    m_acc += x;
    m_cnt++;
    if (m_cnt == (1 << m_log)) begin
      s = m_log + m_drop;
      exp_off.push_back((m_acc + (longint'(1) << (s - 1))) >>> s);
      tag_off.push_back(toff);
      m_cnt = 0;
    end
    @(negedge clk);
    in_valid = 1'b0; restart = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_restart();
    restart = 1'b1; m_cnt = 0;
    @(negedge clk);
    restart = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (dm_valid) begin
        if (exp_dm.size() == 0) check("R8 unexpected dm_valid", 1, 0);
        else check(tag_dm.pop_front(), longint'(dm_data), exp_dm.pop_front());
      end
      if (off_valid) begin
        if (exp_off.size() == 0) check("R3 unexpected off_valid", 1, 0);
        else check(tag_off.pop_front(), longint'(off_data), exp_off.pop_front());
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    check("R1 dm_valid in reset", dm_valid, 0);
    check("R1 off_valid in reset", off_valid, 0);
    rst_n = 1'b1;
    idle(2);
    check("R1 dm_valid after reset", dm_valid, 0);
    check("R1 off_valid after reset", off_valid, 0);

    // R1/R2/R4/R5: L=32, 8.8, offset 768 plus chopped tone; also rounding half up
    len_sel = 2'd0; fmt_sel = 2'd2;
    for (int i = 0; i < 32; i++)
      send(((i % 2) ? -1 : 1) * (i * 37) + 768, 0, (i == 0) ? "R1 first code" : "R2 demod", "R4 offset L32");
    for (int i = 0; i < 32; i++)
      send((i == 0) ? 16 : 0, 0, "R2 demod", "R4 round half up");
    for (int i = 0; i < 32; i++)
      send((i == 0) ? -16 : 0, 0, "R2 demod", "R4 round negative half");

    // R5/R6: L=64, 8.6 with pseudo-random data
    len_sel = 2'd1; fmt_sel = 2'd0;
    for (int i = 0; i < 64; i++)
      send(longint'($signed(16'($urandom))), 0, "R6 demod 8.6", "R5 offset L64 8.6");

    // R8: gaps between samples, L=128, 8.7
    len_sel = 2'd2; fmt_sel = 2'd1;
    for (int i = 0; i < 128; i++) begin
      send(longint'($signed(16'($urandom))) >>> 2, 0, "R8 demod with gaps", "R8 offset with gaps");
      if (i % 5 == 0) idle(i % 3 + 1);
    end

    // R7: change selects mid-frame
    len_sel = 2'd0; fmt_sel = 2'd2;
    for (int i = 0; i < 32; i++) begin
      send(100 + i, 0, "R7 demod latched fmt", "R7 offset latched cfg");
      if (i == 3) begin len_sel = 2'd2; fmt_sel = 2'd0; end
    end
    for (int i = 0; i < 128; i++)
      send(-200 - i, 0, "R7 demod new cfg", "R7 offset new cfg");

    // R3: restart without sample, then with sample
    len_sel = 2'd0; fmt_sel = 2'd3;
    for (int i = 0; i < 11; i++) send(5000, 0, "R3 partial", "R3 partial");
    do_restart();
    idle(2);
    for (int i = 0; i < 32; i++) send(40 + i, 0, (i == 1) ? "R3 code after restart" : "R3 demod", "R3 offset after restart");
    for (int i = 0; i < 7; i++) send(-3000, 0, "R3 partial", "R3 partial");
    for (int i = 0; i < 32; i++) send(i * 3, i == 0, (i == 0) ? "R3 sample with restart" : "R3 demod", "R3 offset restart with sample");

    // R9: full scale, L=128 (len_sel=3), 8.8
    len_sel = 2'd3; fmt_sel = 2'd2;
    for (int i = 0; i < 128; i++) send(-32768, 0, "R9 demod full scale", "R9 offset min");
    for (int i = 0; i < 128; i++) send(32767, 0, "R9 demod full scale", "R9 offset max");

    idle(4);
    check("R4 offsets outstanding", exp_off.size(), 0);
    check("R2 demods outstanding", exp_dm.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule